// File: doc/BRIEF.md
# Stream Symbol Register Front-End

This block puts a small set of memory-mapped registers in front of two symbol streams, one flowing in from a receive PHY and one flowing out to a transmit PHY. It holds no line coding of its own. Any PHY that speaks ready/valid with one symbol per transfer can be attached, and the block only moves symbols between the register bus and those streams.

Each direction has four registers:

- An enable register. While its enable bit is clear, that direction's PHY is held in reset.
- An opaque 16-bit PHY setting, such as a divisor, which is passed to the PHY untouched.
- A status register with a single ready flag.
- A data register.

Each direction keeps exactly one symbol of buffering. Firmware polls the ready flag, then reads or writes the data register. Everything runs on one clock.

The bus register map uses one register per address. Bus data is 16 bits wide. The symbol width is a parameter `SYM_W`, which must be no larger than 16.

Top module: `symfront_top`

## Requirements
- R1: Each enable register (receive at address 0x0, transmit at 0x4) resets to 0. A write stores bit 0 of the write data. A read returns the stored bit in bit 0 and zero in bits 15:1, whatever was written there.
- R2: `rxPhyRst` is 1 while the receive enable bit is 0, and `txPhyRst` is 1 while the transmit enable bit is 0. Each becomes 0 from the cycle after a write that sets its enable bit.
- R3: Each PHY setting register (receive at 0x1, transmit at 0x5) resets to 0. It stores all 16 written bits and reads them back. It drives them unchanged on `rxPhyCfg` or `txPhyCfg`.
- R4: The address map is fixed as follows. Each status register sits right after the two configuration registers of its direction. Addresses 0x8 to 0xF read as zero and ignore writes.

| Address | Register |
|---|---|
| 0x0 | receive enable |
| 0x1 | receive PHY setting |
| 0x2 | receive status |
| 0x3 | receive data |
| 0x4 | transmit enable |
| 0x5 | transmit PHY setting |
| 0x6 | transmit status |
| 0x7 | transmit data |

- R5: The receive status register at 0x2 reads 1 in bit 0 while a received symbol is held. `rxSymReady` is 1 only while receive is enabled and nothing is held. A transfer, meaning `rxSymValid` and `rxSymReady` both high at a clock edge, captures `rxSymData`.
- R6: A read of 0x3 while a symbol is held returns that symbol zero-extended and clears the receive ready flag at the same edge. A read while nothing is held returns 0 and changes nothing.
- R7: The transmit status register at 0x6 reads 1 in bit 0 when transmit is enabled and its holding register is empty.
- R8: A write to 0x7 while transmit ready is 1 loads the low `SYM_W` bits. From the next cycle, `txSymValid` is 1 and `txSymData` holds that symbol, and both stay stable until `txSymReady` is seen high at an edge. A write while transmit ready is 0 is dropped.
- R9: Writing 0 to an enable bit, or leaving it at 0, empties that direction's holding register at the same edge. After this, receive status reads 0 and `txSymValid` is 0.
- R10: `busRdData` is registered. It carries the value selected by a read in the cycle after `busRdEn`, and is 0 after any edge without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for bus, registers and streams |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Register address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 16 | Write data |
| busRdEn | input | 1 | Read strobe, one cycle per read |
| busRdData | output | 16 | Registered read data |
| rxPhyRst | output | 1 | Reset to the receive PHY |
| rxPhyCfg | output | 16 | Opaque receive PHY setting |
| rxSymValid | input | 1 | Receive PHY offers a symbol |
| rxSymReady | output | 1 | Block can take a receive symbol |
| rxSymData | input | SYM_W | Received symbol |
| txPhyRst | output | 1 | Reset to the transmit PHY |
| txPhyCfg | output | 16 | Opaque transmit PHY setting |
| txSymValid | output | 1 | A transmit symbol is offered |
| txSymReady | input | 1 | Transmit PHY takes the symbol |
| txSymData | output | SYM_W | Symbol to transmit |

## Verification
Every register write or stream handshake takes effect at the next rising edge, so its result is due one cycle later. The bench drives inputs on the falling edge and samples on the following falling edge, half a cycle after the edge that updates the state. A read result is due one cycle after the read strobe, at the same point where the bench's read task takes it. Stream outputs such as `rxSymReady` are sampled both before and after the handshake edge, which pins down the exact cycle in which each one changes.

// File: rtl/symfront_pkg.sv
package symfront_pkg;
  localparam int ADDR_W  = 4;
  localparam int BUS_W   = 16;
  localparam int PHY_W   = 16;
  localparam int NUM_DIR = 2;
  localparam int DIR_RX  = 0;
  localparam int DIR_TX  = 1;
  localparam int DIR_SPAN = 4;

  typedef enum logic [ADDR_W-1:0] {
    SEL_RX_EN   = 4'h0,
    SEL_RX_PHY  = 4'h1,
    SEL_RX_STAT = 4'h2,
    SEL_RX_DATA = 4'h3,
    SEL_TX_EN   = 4'h4,
    SEL_TX_PHY  = 4'h5,
    SEL_TX_STAT = 4'h6,
    SEL_TX_DATA = 4'h7,
    SEL_NONE    = 4'hF
  } regSel_e;

  typedef struct packed {
    logic [NUM_DIR-1:0] enWr;
    logic [NUM_DIR-1:0] phyWr;
    logic               txDataWr;
    logic               rxDataRd;
    logic               rdEn;
    regSel_e            rdSel;
  } strobes_t;
endpackage

// File: rtl/symfront_ctrl.sv
module symfront_ctrl
  import symfront_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output strobes_t          strobes
);
  logic inMap;
  assign inMap = (busAddr < ADDR_W'(NUM_DIR * DIR_SPAN));

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(d * DIR_SPAN);
    assign strobes.enWr[d]  = busWrEn && (busAddr == BASE);
    assign strobes.phyWr[d] = busWrEn && (busAddr == BASE + ADDR_W'(1));
  end

  assign strobes.txDataWr = busWrEn && (busAddr == SEL_TX_DATA);
  assign strobes.rxDataRd = busRdEn && (busAddr == SEL_RX_DATA);
  assign strobes.rdEn     = busRdEn;
  assign strobes.rdSel    = inMap ? regSel_e'(busAddr) : SEL_NONE;
endmodule

// File: rtl/symfront_datapath.sv
module symfront_datapath
  import symfront_pkg::*;
#(
  parameter int SYM_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strobes,
  input  logic [BUS_W-1:0] busWrData,
  output logic [BUS_W-1:0] busRdData,
  output logic             rxPhyRst,
  output logic [PHY_W-1:0] rxPhyCfg,
  input  logic             rxSymValid,
  output logic             rxSymReady,
  input  logic [SYM_W-1:0] rxSymData,
  output logic             txPhyRst,
  output logic [PHY_W-1:0] txPhyCfg,
  output logic             txSymValid,
  input  logic             txSymReady,
  output logic [SYM_W-1:0] txSymData
);
  logic [NUM_DIR-1:0] dirEn;
  logic [NUM_DIR-1:0] dirFlush;
  logic [PHY_W-1:0]   phyCfg [NUM_DIR];

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        dirEn[d]  <= 1'b0;
        phyCfg[d] <= '0;
      end else begin
        if (strobes.enWr[d])  dirEn[d]  <= busWrData[0];
        if (strobes.phyWr[d]) phyCfg[d] <= busWrData[PHY_W-1:0];
      end
    end
    assign dirFlush[d] = !dirEn[d] || (strobes.enWr[d] && !busWrData[0]);

    assert_en_store_R1: assert property (@(posedge clk) disable iff (!rstN)
      strobes.enWr[d] |=> dirEn[d] == $past(busWrData[0]));
  end

  assign rxPhyRst = !dirEn[DIR_RX];
  assign txPhyRst = !dirEn[DIR_TX];
  assign rxPhyCfg = phyCfg[DIR_RX];
  assign txPhyCfg = phyCfg[DIR_TX];

  // receive holding register
  logic             rxFull;
  logic [SYM_W-1:0] rxHold;
  assign rxSymReady = dirEn[DIR_RX] && !rxFull;

  always_ff @(posedge clk) begin
    if (!rstN || dirFlush[DIR_RX]) begin
      rxFull <= 1'b0;
      rxHold <= '0;
    end else if (rxSymValid && rxSymReady) begin
      rxFull <= 1'b1;
      rxHold <= rxSymData;
    end else if (strobes.rxDataRd && rxFull) begin
      rxFull <= 1'b0;
    end
  end

  // transmit holding register
  logic             txFull;
  logic [SYM_W-1:0] txHold;
  logic             txCanTake;
  assign txCanTake  = dirEn[DIR_TX] && !txFull;
  assign txSymValid = txFull;
  assign txSymData  = txHold;

  always_ff @(posedge clk) begin
    if (!rstN || dirFlush[DIR_TX]) begin
      txFull <= 1'b0;
      txHold <= '0;
    end else if (strobes.txDataWr && txCanTake) begin
      txFull <= 1'b1;
      txHold <= busWrData[SYM_W-1:0];
    end else if (txFull && txSymReady) begin
      txFull <= 1'b0;
    end
  end

  // read mux and registered read data
  logic [BUS_W-1:0] rdVal;
  always_comb begin
    rdVal = '0;
    unique case (strobes.rdSel)
      SEL_RX_EN:   rdVal[0] = dirEn[DIR_RX];
      SEL_RX_PHY:  rdVal[PHY_W-1:0] = phyCfg[DIR_RX];
      SEL_RX_STAT: rdVal[0] = rxFull;
      SEL_RX_DATA: rdVal[SYM_W-1:0] = rxFull ? rxHold : '0;
      SEL_TX_EN:   rdVal[0] = dirEn[DIR_TX];
      SEL_TX_PHY:  rdVal[PHY_W-1:0] = phyCfg[DIR_TX];
      SEL_TX_STAT: rdVal[0] = txCanTake;
      default:     rdVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) busRdData <= '0;
    else       busRdData <= strobes.rdEn ? rdVal : '0;
  end

  assert_rst_release_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.enWr[DIR_RX] && busWrData[0] |=> !rxPhyRst);
  assert_rx_capture_R5: assert property (@(posedge clk) disable iff (!rstN)
    rxSymValid && rxSymReady && !dirFlush[DIR_RX] |=> rxFull && rxHold == $past(rxSymData));
  assert_rx_pop_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rxDataRd && rxFull && dirEn[DIR_RX] |=> !rxFull);
  assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    txSymValid && !txSymReady && !dirFlush[DIR_TX] |=> txSymValid && $stable(txSymData));
  assert_flush_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.enWr[DIR_TX] && !busWrData[0] |=> !txSymValid);
  assert_idle_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdEn |=> busRdData == '0);
endmodule

// File: rtl/symfront_top.sv
module symfront_top
  import symfront_pkg::*;
#(
  parameter int SYM_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [BUS_W-1:0]  busWrData,
  input  logic              busRdEn,
  output logic [BUS_W-1:0]  busRdData,
  output logic              rxPhyRst,
  output logic [PHY_W-1:0]  rxPhyCfg,
  input  logic              rxSymValid,
  output logic              rxSymReady,
  input  logic [SYM_W-1:0]  rxSymData,
  output logic              txPhyRst,
  output logic [PHY_W-1:0]  txPhyCfg,
  output logic              txSymValid,
  input  logic              txSymReady,
  output logic [SYM_W-1:0]  txSymData
);
  strobes_t strobes;

  symfront_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strobes (strobes)
  );

  symfront_datapath #(.SYM_W(SYM_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .busWrData  (busWrData),
    .busRdData  (busRdData),
    .rxPhyRst   (rxPhyRst),
    .rxPhyCfg   (rxPhyCfg),
    .rxSymValid (rxSymValid),
    .rxSymReady (rxSymReady),
    .rxSymData  (rxSymData),
    .txPhyRst   (txPhyRst),
    .txPhyCfg   (txPhyCfg),
    .txSymValid (txSymValid),
    .txSymReady (txSymReady),
    .txSymData  (txSymData)
  );
endmodule

// File: tb/sim_symfront_top.sv
module sim_symfront_top;
  localparam int SYM_W = 8;
  localparam int NVEC  = 14;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [15:0] busRdData;
  logic        rxPhyRst, txPhyRst, rxSymReady, txSymValid;
  logic [15:0] rxPhyCfg, txPhyCfg;
  logic        rxSymValid = 1'b0;
  logic        txSymReady = 1'b0;
  logic [SYM_W-1:0] rxSymData = '0;
  logic [SYM_W-1:0] txSymData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  symfront_top #(.SYM_W(SYM_W)) u0 (.*);

  // entry: {isRead, addr[3:0], data[15:0], expected[15:0]}
  localparam logic [36:0] VEC [NVEC] = '{
    {1'b1, 4'h0, 16'h0000, 16'h0000},
    {1'b0, 4'h0, 16'hFFFF, 16'h0000},
    {1'b1, 4'h0, 16'h0000, 16'h0001},
    {1'b0, 4'h1, 16'hA5C3, 16'h0000},
    {1'b1, 4'h1, 16'h0000, 16'hA5C3},
    {1'b0, 4'h5, 16'h1234, 16'h0000},
    {1'b1, 4'h5, 16'h0000, 16'h1234},
    {1'b1, 4'h6, 16'h0000, 16'h0000},
    {1'b0, 4'h4, 16'h0003, 16'h0000},
    {1'b1, 4'h4, 16'h0000, 16'h0001},
    {1'b1, 4'h6, 16'h0000, 16'h0001},
    {1'b1, 4'h2, 16'h0000, 16'h0000},
    {1'b0, 4'h9, 16'hBEEF, 16'h0000},
    {1'b1, 4'h9, 16'h0000, 16'h0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic rxOffer(input logic [SYM_W-1:0] s);
    @(negedge clk);
    rxSymValid = 1'b1; rxSymData = s;
    @(negedge clk);
    rxSymValid = 1'b0;
  endtask

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    check("R1 rx enable reset", {31'b0, rxPhyRst}, 32'd1);
    check("R2 tx phy reset at reset", {31'b0, txPhyRst}, 32'd1);
    check("R5 rx ready low when disabled", {31'b0, rxSymReady}, 32'd0);
    check("R10 read data reset", {16'b0, busRdData}, 32'd0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][36]) begin
        busRead(VEC[i][35:32], r);
        check($sformatf("R1/R3/R4/R7 vector %0d", i), {16'b0, r}, {16'b0, VEC[i][15:0]});
      end else begin
        busWrite(VEC[i][35:32], VEC[i][31:16]);
      end
    end
    check("R3 rx phy cfg port", {16'b0, rxPhyCfg}, 32'hA5C3);
    check("R3 tx phy cfg port", {16'b0, txPhyCfg}, 32'h1234);
    check("R2 rx phy reset released", {31'b0, rxPhyRst}, 32'd0);
    check("R10 idle read data zero", {16'b0, busRdData}, 32'd0);

    // R5/R6 receive path
    @(negedge clk);
    rxSymValid = 1'b1; rxSymData = 8'h5A;
    #1 check("R5 rx ready before capture", {31'b0, rxSymReady}, 32'd1);
    @(negedge clk);
    rxSymValid = 1'b0;
    check("R5 rx ready low when full", {31'b0, rxSymReady}, 32'd0);
    busRead(4'h2, r);
    check("R5 rx status set", {16'b0, r}, 32'd1);
    busRead(4'h3, r);
    check("R6 rx data read", {16'b0, r}, 32'h5A);
    busRead(4'h2, r);
    check("R6 rx status cleared by read", {16'b0, r}, 32'd0);
    busRead(4'h3, r);
    check("R6 empty read returns zero", {16'b0, r}, 32'd0);

    // R9 receive flush
    rxOffer(8'hC7);
    busWrite(4'h0, 16'h0000);
    check("R2 rx phy reset on disable", {31'b0, rxPhyRst}, 32'd1);
    busWrite(4'h0, 16'h0001);
    busRead(4'h2, r);
    check("R9 rx flushed by disable", {16'b0, r}, 32'd0);

    // R7/R8 transmit path
    busWrite(4'h7, 16'h003C);
    check("R8 tx valid after write", {31'b0, txSymValid}, 32'd1);
    check("R8 tx data after write", {24'b0, txSymData}, 32'h3C);
    busRead(4'h6, r);
    check("R7 tx status busy", {16'b0, r}, 32'd0);
    busWrite(4'h7, 16'h0077);
    check("R8 write while busy dropped", {24'b0, txSymData}, 32'h3C);
    @(negedge clk);
    txSymReady = 1'b1;
    @(negedge clk);
    txSymReady = 1'b0;
    check("R8 tx valid cleared on accept", {31'b0, txSymValid}, 32'd0);
    busRead(4'h6, r);
    check("R7 tx status ready again", {16'b0, r}, 32'd1);

    // R9 transmit flush and disabled write
    busWrite(4'h7, 16'h0011);
    busWrite(4'h4, 16'h0000);
    check("R9 tx flushed by disable", {31'b0, txSymValid}, 32'd0);
    check("R2 tx phy reset on disable", {31'b0, txPhyRst}, 32'd1);
    busWrite(4'h7, 16'h0022);
    check("R8 write while disabled dropped", {31'b0, txSymValid}, 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule